// File: doc/BRIEF.md
# Accumulator Normalization Step Unit

This block advances normalization of a wide signed accumulator by one bit position per strobe. The accumulator is laid out as a guard (extension) field above a high word and a low word, 56 bits in the default configuration (8 + 24 + 24). A separate 16-bit signed shift counter records the net number of positions moved, so that after a run of steps the counter holds the exponent adjustment that matches the normalized mantissa.

Each strobe looks at three status flags taken from the accumulator as it stands before the step. A flag shows whether the guard field carries significant bits, one whether the value is unnormalized, and one whether the value is zero. If the guard bits are in use, the unit shifts right by one and increments the counter. If they are not in use and the value is unnormalized and nonzero, the unit shifts left by one and decrements the counter. Otherwise the step does nothing to either register. A synchronous load port seeds the accumulator, the counter and the overflow and limit flags. A controller repeats the strobe, usually once per bit position, until the value stops changing.

Top module: `acc_norm_step`

## Requirements
- R1: The status outputs always describe the current accumulator. `flag_e_o` is 1 unless bits 55..47 are all equal. `flag_u_o` is 1 when bit 47 equals bit 46. `flag_z_o` is 1 when all 56 bits are zero.
- R2: A step where E=0, U=1 and Z=0 shifts the accumulator left by one bit with a 0 entering bit 0, and decrements the counter by 1.
- R3: A step where E=1 shifts the accumulator right by one bit with bit 55 keeping its value, and increments the counter by 1.
- R4: A step taken when the value is normalized (E=0, U=0) or zero leaves both the accumulator and the counter unchanged.
- R5: The counter wraps modulo 2^16: decrementing 0x0000 gives 0xFFFF, and incrementing 0xFFFF gives 0x0000.
- R6: When `load_i` is high, the next clock writes the accumulator, the counter, the overflow flag and the limit flag from the load inputs. A step strobed in the same cycle is ignored.
- R7: Every step that is not overridden by a load clears the overflow and limit flags, including a step that does nothing.
- R8: With neither `load_i` nor `step_i` high, all registers keep their values.
- R9: After reset the accumulator, the counter, the overflow flag and the limit flag are all zero, so Z=1, U=1 and E=0.
- R10: Starting from accumulator 0x00_000000_000001 with counter 0x0000, 47 steps in a row end with accumulator 0x00_400000_000000 and counter 0xFFD2 (-46). The last of these steps does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Load strobe; takes priority over a step |
| load_acc_i | input | 56 | Accumulator value to load |
| load_cnt_i | input | 16 | Shift counter value to load |
| load_ovf_i | input | 1 | Overflow flag value to load |
| load_lim_i | input | 1 | Limit flag value to load |
| step_i | input | 1 | Perform one normalization step |
| acc_o | output | 56 | Current accumulator |
| cnt_o | output | 16 | Current shift counter |
| flag_e_o | output | 1 | Guard field in use |
| flag_u_o | output | 1 | Value unnormalized |
| flag_z_o | output | 1 | Value is zero |
| flag_ovf_o | output | 1 | Overflow flag |
| flag_lim_o | output | 1 | Limit flag |

## Verification
The flags are decoded combinationally from the accumulator register, so a wrong accumulator bit shows up in the same cycle as a flag mismatch. It then shows up as a wrong shift direction on the next strobe. A counter that steps the wrong way, or changes on a step that should do nothing, shows a wrong `cnt_o` one clock after that strobe. The error stays until the next load. Because every step is compared against an arithmetic reference right after the edge, any divergence is caught at the first step that produces it. Walking single-bit positive and negative values run all the way to normalization, so every shift position in both directions is reached.

// File: rtl/acc_norm_pkg.sv
`timescale 1ns/1ps
package acc_norm_pkg;

   typedef enum logic [1:0] {
      ACT_HOLD  = 2'd0,
      ACT_LEFT  = 2'd1,
      ACT_RIGHT = 2'd2
   } norm_act_e;

   typedef struct packed {
      logic ext_used;
      logic unnorm;
      logic zero;
   } norm_flags_t;

endpackage

// File: rtl/acc_norm_flags.sv
`timescale 1ns/1ps
module acc_norm_flags
   import acc_norm_pkg::*;
#(
   parameter int EXT_W = 8,
   parameter int HI_W  = 24,
   parameter int LO_W  = 24
) (
   input  logic [EXT_W+HI_W+LO_W-1:0] acc_i,
   output norm_flags_t                flags_o
);
   localparam int ACC_W  = EXT_W + HI_W + LO_W;
   localparam int TOP_MB = HI_W + LO_W - 1;   // mantissa sign position

   // one inequality per adjacent pair from the mantissa sign up to the MSB
   logic [EXT_W-1:0] guard_diff;

   generate
      for (genvar i = 0; i < EXT_W; i++) begin : g_guard
         assign guard_diff[i] = acc_i[TOP_MB+i+1] ^ acc_i[TOP_MB+i];
      end
   endgenerate

   always_comb begin
      flags_o.ext_used = |guard_diff;
      flags_o.unnorm   = ~(acc_i[TOP_MB] ^ acc_i[TOP_MB-1]);
      flags_o.zero     = ~|acc_i[ACC_W-1:0];
   end
endmodule

// File: rtl/acc_norm_decide.sv
`timescale 1ns/1ps
module acc_norm_decide
   import acc_norm_pkg::*;
(
   input  logic        step_i,
   input  logic        load_i,
   input  norm_flags_t flags_i,
   output norm_act_e   act_o
);
   always_comb begin
      act_o = ACT_HOLD;
      if (step_i && !load_i) begin
         if (flags_i.ext_used)
            act_o = ACT_RIGHT;
         else if (flags_i.unnorm && !flags_i.zero)
            act_o = ACT_LEFT;
      end
   end
endmodule

// File: rtl/acc_norm_shift.sv
`timescale 1ns/1ps
module acc_norm_shift
   import acc_norm_pkg::*;
#(
   parameter int ACC_W = 56
) (
   input  logic [ACC_W-1:0] acc_i,
   input  norm_act_e        act_i,
   output logic [ACC_W-1:0] acc_o
);
   always_comb begin
      unique case (act_i)
         ACT_LEFT:  acc_o = {acc_i[ACC_W-2:0], 1'b0};
         ACT_RIGHT: acc_o = {acc_i[ACC_W-1], acc_i[ACC_W-1:1]};
         default:   acc_o = acc_i;
      endcase
   end
endmodule

// File: rtl/acc_norm_counter.sv
`timescale 1ns/1ps
module acc_norm_counter
   import acc_norm_pkg::*;
#(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [CNT_W-1:0] load_val_i,
   input  norm_act_e        act_i,
   output logic [CNT_W-1:0] cnt_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_o <= '0;
      else if (load_i)
         cnt_o <= load_val_i;
      else begin
         unique case (act_i)
            ACT_LEFT:  cnt_o <= cnt_o - ONE;
            ACT_RIGHT: cnt_o <= cnt_o + ONE;
            default:   cnt_o <= cnt_o;
         endcase
      end
   end
endmodule

// File: rtl/acc_norm_step.sv
`timescale 1ns/1ps
module acc_norm_step
   import acc_norm_pkg::*;
#(
   parameter int EXT_W = 8,
   parameter int HI_W  = 24,
   parameter int LO_W  = 24,
   parameter int CNT_W = 16
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       load_i,
   input  logic [EXT_W+HI_W+LO_W-1:0] load_acc_i,
   input  logic [CNT_W-1:0]           load_cnt_i,
   input  logic                       load_ovf_i,
   input  logic                       load_lim_i,
   input  logic                       step_i,
   output logic [EXT_W+HI_W+LO_W-1:0] acc_o,
   output logic [CNT_W-1:0]           cnt_o,
   output logic                       flag_e_o,
   output logic                       flag_u_o,
   output logic                       flag_z_o,
   output logic                       flag_ovf_o,
   output logic                       flag_lim_o
);
   localparam int ACC_W = EXT_W + HI_W + LO_W;

   generate
      if (EXT_W < 1) begin : g_bad_ext
         $error("acc_norm_step: EXT_W must be at least 1");
      end
      if (HI_W + LO_W < 2) begin : g_bad_mant
         $error("acc_norm_step: mantissa must be at least 2 bits");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("acc_norm_step: CNT_W must be at least 2");
      end
   endgenerate

   logic [ACC_W-1:0] acc_q;
   logic [ACC_W-1:0] acc_shifted;
   norm_flags_t      flags;
   norm_act_e        act;
   logic             ovf_q;
   logic             lim_q;

   acc_norm_flags #(.EXT_W(EXT_W), .HI_W(HI_W), .LO_W(LO_W)) u_flags (
      .acc_i   (acc_q),
      .flags_o (flags)
   );

   acc_norm_decide u_decide (
      .step_i  (step_i),
      .load_i  (load_i),
      .flags_i (flags),
      .act_o   (act)
   );

   acc_norm_shift #(.ACC_W(ACC_W)) u_shift (
      .acc_i (acc_q),
      .act_i (act),
      .acc_o (acc_shifted)
   );

   acc_norm_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load_i),
      .load_val_i (load_cnt_i),
      .act_i      (act),
      .cnt_o      (cnt_o)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
         ovf_q <= 1'b0;
         lim_q <= 1'b0;
      end else if (load_i) begin
         acc_q <= load_acc_i;
         ovf_q <= load_ovf_i;
         lim_q <= load_lim_i;
      end else begin
         acc_q <= acc_shifted;
         if (step_i) begin
            ovf_q <= 1'b0;
            lim_q <= 1'b0;
         end
      end
   end

   assign acc_o      = acc_q;
   assign flag_e_o   = flags.ext_used;
   assign flag_u_o   = flags.unnorm;
   assign flag_z_o   = flags.zero;
   assign flag_ovf_o = ovf_q;
   assign flag_lim_o = lim_q;
endmodule

// File: rtl/acc_norm_step_chk.sv
`timescale 1ns/1ps
module acc_norm_step_chk #(
   parameter int EXT_W = 8,
   parameter int HI_W  = 24,
   parameter int LO_W  = 24,
   parameter int CNT_W = 16
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       load_i,
   input logic [EXT_W+HI_W+LO_W-1:0] load_acc_i,
   input logic [CNT_W-1:0]           load_cnt_i,
   input logic                       load_ovf_i,
   input logic                       load_lim_i,
   input logic                       step_i,
   input logic [EXT_W+HI_W+LO_W-1:0] acc_o,
   input logic [CNT_W-1:0]           cnt_o,
   input logic                       flag_e_o,
   input logic                       flag_u_o,
   input logic                       flag_z_o,
   input logic                       flag_ovf_o,
   input logic                       flag_lim_o
);
   localparam int ACC_W = EXT_W + HI_W + LO_W;
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |=> (acc_o == $past(load_acc_i)) && (cnt_o == $past(load_cnt_i))
                 && (flag_ovf_o == $past(load_ovf_i)) && (flag_lim_o == $past(load_lim_i))); // R6

   AST_LEFT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i && !flag_e_o && flag_u_o && !flag_z_o) |=>
         (acc_o == {$past(acc_o[ACC_W-2:0]), 1'b0}) && (cnt_o == $past(cnt_o) - ONE)); // R2

   AST_RIGHT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i && flag_e_o) |=>
         (acc_o == {$past(acc_o[ACC_W-1]), $past(acc_o[ACC_W-1:1])}) && (cnt_o == $past(cnt_o) + ONE)); // R3

   AST_HOLD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i && !flag_e_o && (!flag_u_o || flag_z_o)) |=>
         $stable(acc_o) && $stable(cnt_o)); // R4

   AST_STEP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (step_i && !load_i) |=> !flag_ovf_o && !flag_lim_o); // R7

   AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!step_i && !load_i) |=> $stable(acc_o) && $stable(cnt_o)
                               && $stable(flag_ovf_o) && $stable(flag_lim_o)); // R8

   AST_ZERO_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      flag_z_o |-> flag_u_o && !flag_e_o); // R1
endmodule

bind acc_norm_step acc_norm_step_chk #(
   .EXT_W(EXT_W), .HI_W(HI_W), .LO_W(LO_W), .CNT_W(CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .load_i     (load_i),
   .load_acc_i (load_acc_i),
   .load_cnt_i (load_cnt_i),
   .load_ovf_i (load_ovf_i),
   .load_lim_i (load_lim_i),
   .step_i     (step_i),
   .acc_o      (acc_o),
   .cnt_o      (cnt_o),
   .flag_e_o   (flag_e_o),
   .flag_u_o   (flag_u_o),
   .flag_z_o   (flag_z_o),
   .flag_ovf_o (flag_ovf_o),
   .flag_lim_o (flag_lim_o)
);

// File: tb/acc_norm_step_test.sv
`timescale 1ns/1ps
module acc_norm_step_test;
   localparam int ACC_W = 56;
   localparam int CNT_W = 16;

   logic clk = 1'b0;
   always #2.5 clk = ~clk;

   logic             rst_n = 1'b0;
   logic             load_i = 1'b0;
   logic [ACC_W-1:0] load_acc_i = '0;
   logic [CNT_W-1:0] load_cnt_i = '0;
   logic             load_ovf_i = 1'b0;
   logic             load_lim_i = 1'b0;
   logic             step_i = 1'b0;
   logic [ACC_W-1:0] acc_o;
   logic [CNT_W-1:0] cnt_o;
   logic             flag_e_o, flag_u_o, flag_z_o, flag_ovf_o, flag_lim_o;

   acc_norm_step uut (
      .clk(clk), .rst_n(rst_n), .load_i(load_i), .load_acc_i(load_acc_i),
      .load_cnt_i(load_cnt_i), .load_ovf_i(load_ovf_i), .load_lim_i(load_lim_i),
      .step_i(step_i), .acc_o(acc_o), .cnt_o(cnt_o), .flag_e_o(flag_e_o),
      .flag_u_o(flag_u_o), .flag_z_o(flag_z_o), .flag_ovf_o(flag_ovf_o),
      .flag_lim_o(flag_lim_o)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   logic [ACC_W-1:0] m_acc;
   logic [CNT_W-1:0] m_cnt;
   logic             m_ovf, m_lim;

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // reference flag decode, from the requirement text
   function automatic bit ref_e(input logic [ACC_W-1:0] x);
      return !((x[55:47] == 9'h000) || (x[55:47] == 9'h1FF));
   endfunction
   function automatic bit ref_u(input logic [ACC_W-1:0] x);
      return x[47] == x[46];
   endfunction
   function automatic bit ref_z(input logic [ACC_W-1:0] x);
      return x == '0;
   endfunction

   task automatic check_state(input string tag);
      chk(acc_o == m_acc, tag, 64'(acc_o), 64'(m_acc));
      chk(cnt_o == m_cnt, tag, 64'(cnt_o), 64'(m_cnt));
      chk(flag_e_o == ref_e(m_acc), "R1 E", 64'(flag_e_o), 64'(ref_e(m_acc)));
      chk(flag_u_o == ref_u(m_acc), "R1 U", 64'(flag_u_o), 64'(ref_u(m_acc)));
      chk(flag_z_o == ref_z(m_acc), "R1 Z", 64'(flag_z_o), 64'(ref_z(m_acc)));
      chk({flag_ovf_o, flag_lim_o} == {m_ovf, m_lim}, "R7 V/L",
          64'({flag_ovf_o, flag_lim_o}), 64'({m_ovf, m_lim}));
   endtask

   task automatic do_load(input logic [ACC_W-1:0] a, input logic [CNT_W-1:0] c,
                          input logic v, input logic l);
      @(negedge clk);
      load_i = 1'b1; load_acc_i = a; load_cnt_i = c; load_ovf_i = v; load_lim_i = l;
      @(negedge clk);
      load_i = 1'b0;
      m_acc = a; m_cnt = c; m_ovf = v; m_lim = l;
      check_state("R6 load");
   endtask

   // returns 1 when the step changed nothing
   task automatic do_step(output bit was_hold);
      string tag;
      was_hold = 1'b0;
      if (ref_e(m_acc)) begin
         tag = "R3 right";
         m_acc = $signed(m_acc) >>> 1;
         m_cnt = m_cnt + 16'd1;
      end else if (ref_u(m_acc) && !ref_z(m_acc)) begin
         tag = "R2 left";
         m_acc = m_acc * 2;
         m_cnt = m_cnt - 16'd1;
      end else begin
         tag = "R4 hold";
         was_hold = 1'b1;
      end
      m_ovf = 1'b0; m_lim = 1'b0;
      @(negedge clk);
      step_i = 1'b1;
      @(negedge clk);
      step_i = 1'b0;
      check_state(tag);
   endtask

   task automatic run_to_norm(input logic [ACC_W-1:0] a, input logic [CNT_W-1:0] c);
      bit h;
      do_load(a, c, 1'b1, 1'b1);
      for (int s = 0; s < 64; s++) begin
         do_step(h);
         if (h) break;
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         summary();
         $finish;
      end
   end

   initial begin
      bit h;
      logic [63:0] lf;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R9 reset state
      m_acc = '0; m_cnt = '0; m_ovf = 1'b0; m_lim = 1'b0;
      check_state("R9 reset");

      // R10 worked sequence
      do_load(56'h00_000000_000001, 16'h0000, 1'b0, 1'b0);
      for (int s = 0; s < 47; s++) do_step(h);
      chk(acc_o == 56'h00_400000_000000, "R10 acc", 64'(acc_o), 64'h00_400000_000000);
      chk(cnt_o == 16'hFFD2, "R10 cnt", 64'(cnt_o), 64'hFFD2);
      chk(h == 1'b1, "R10 last step no-op", 64'(h), 64'd1);

      // sweep: walking positive and negative single bits
      for (int k = 0; k < ACC_W; k++) begin
         run_to_norm(56'd1 << k, 16'(k * 37));
         run_to_norm(-(56'd1 << k), 16'(k * 101));
      end
      // zero, extremes and pseudo-random patterns
      run_to_norm('0, 16'h1234);
      run_to_norm(56'h7F_FFFFFF_FFFFFF, 16'h0000);
      run_to_norm(56'h80_000000_000000, 16'h0000);
      run_to_norm(56'hFF_C00000_000000, 16'h0005);
      lf = 64'h9E37_79B9_7F4A_7C15;
      for (int r = 0; r < 200; r++) begin
         lf = lf ^ (lf << 13); lf = lf ^ (lf >> 7); lf = lf ^ (lf << 17);
         run_to_norm(lf[ACC_W-1:0] >> lf[61:58], lf[63:48]);
      end

      // R5 counter wrap both ways
      do_load(56'h00_000000_000001, 16'h0000, 1'b0, 1'b0);
      do_step(h);
      chk(cnt_o == 16'hFFFF, "R5 wrap down", 64'(cnt_o), 64'hFFFF);
      do_load(56'h80_000000_000000, 16'hFFFF, 1'b0, 1'b0);
      do_step(h);
      chk(cnt_o == 16'h0000, "R5 wrap up", 64'(cnt_o), 64'h0000);

      // R6 load beats a simultaneous step
      do_load(56'h00_000000_000010, 16'h0010, 1'b0, 1'b0);
      @(negedge clk);
      load_i = 1'b1; step_i = 1'b1;
      load_acc_i = 56'h00_000000_000100; load_cnt_i = 16'h0033;
      load_ovf_i = 1'b1; load_lim_i = 1'b0;
      @(negedge clk);
      load_i = 1'b0; step_i = 1'b0;
      m_acc = 56'h00_000000_000100; m_cnt = 16'h0033; m_ovf = 1'b1; m_lim = 1'b0;
      check_state("R6 load priority");

      // R7 a no-op step still clears V and L
      do_load(56'h00_400000_000000, 16'h0007, 1'b1, 1'b1);
      do_step(h);
      chk(h == 1'b1, "R7 step was no-op", 64'(h), 64'd1);
      chk(!flag_ovf_o && !flag_lim_o, "R7 cleared", 64'({flag_ovf_o, flag_lim_o}), 64'd0);

      // R8 idle cycles keep everything
      do_load(56'h00_000000_000003, 16'h0042, 1'b1, 1'b0);
      repeat (4) @(negedge clk);
      check_state("R8 idle");

      done = 1'b1;
      summary();
      $finish;
   end
endmodule